// File: doc/BRIEF.md
# Converter register update sequencer

This block sits behind a two-wire serial byte receiver that has already matched the address byte. It turns the write stream that follows into register loads for a 16-bit converter. The first byte of each transaction is a control byte. Every later pair of bytes, high half first and then low half, forms one 16-bit word. The control byte chooses where that word goes: into a holding register only, or into both the holding register and the output register that drives the converter.

A word is committed only on the falling edge of the acknowledge that follows its low byte. The receiver reports that edge as a one-cycle strobe. One control byte covers any number of word pairs that follow it in the same transaction. A control byte with either of its two top bits set is still acknowledged by the receiver, but it blocks every load until a new transaction brings a new control byte. A one-cycle pulse marks each load of the output register.

Top module: `conv_update_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the holding register, the output register, the pulse and the stored control byte are all cleared to zero.
- R2: After `txn_start`, the first byte is taken as the control byte. Each following pair forms the word {first byte, second byte}, with the first byte in bits 15:8.
- R3: A word is committed at the clock edge where `ack_fall` is seen after its low byte. Before that, neither register changes. An `ack_fall` that does not follow a low byte has no effect.
- R4: With control bits [7:6] = 00 and [5:4] = 00, a commit writes the word to the holding register only. The output register keeps its value and no pulse appears.
- R5: With control bits [7:6] = 00 and [5:4] = 01, a commit writes the word to both registers. `upd_pulse` is high for exactly the one cycle in which the new output value first appears.
- R6: With control bit 7 or bit 6 set, no commit in that transaction changes either register.
- R7: With control bits [5:4] = 10 or 11, a commit changes neither register.
- R8: Further word pairs in the same transaction each commit again under the same control byte, with no new control byte.
- R9: A high byte, or a high and low byte pair, that is cut off by `txn_stop` or by a new `txn_start` before its acknowledge edge is dropped with no load.
- R10: Every new transaction needs its own control byte. The first byte after `txn_start` is never taken as word data.
- R11: `upd_pulse` is high only in a cycle in which the output register has just been loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_byte | input | 8 | Received byte value |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| ack_fall | input | 1 | One-cycle strobe: falling edge of an acknowledge |
| txn_start | input | 1 | One-cycle strobe: a write transaction to this device begins |
| txn_stop | input | 1 | One-cycle strobe: the transaction ends |
| tmp_word | output | 16 | Holding register |
| out_word | output | 16 | Output register feeding the converter |
| upd_pulse | output | 1 | High for one cycle after each output-register load |

## Verification
The bench checks that a new transaction treats its first byte as control. A design that kept the previous control byte would shift every later word by one byte. It checks that loads wait for the acknowledge edge after the low byte. A design that committed on the byte strobe would change the registers one event too early, and a design that accepted a stray acknowledge after a lone high byte would load half a word. It also cuts transactions off between the two bytes of a pair and between the low byte and its acknowledge, so a design that leaves a stale partial word pending shows a wrong load later. The two blocking cases, top bits set and the unused mode codes, must leave both registers and the pulse untouched.

// File: rtl/conv_seq_pkg.sv
// Package: shared types and control-byte decoding for the converter
// register update sequencer.
package conv_seq_pkg;

    // Position of the control-byte fields
    localparam int CTRL_W      = 8;
    localparam int CTRL_BLK_HI = 7;
    localparam int CTRL_BLK_LO = 6;
    localparam int CTRL_MOD_HI = 5;
    localparam int CTRL_MOD_LO = 4;

    // Sequencer phase within a write transaction
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // no transaction open
        PH_CTRL = 3'd1,   // next byte is the control byte
        PH_HIGH = 3'd2,   // next byte is a high byte
        PH_LOW  = 3'd3,   // next byte is a low byte
        PH_ACK  = 3'd4    // word assembled, waiting for acknowledge edge
    } phase_t;

    // Register destination chosen by the control byte
    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_TEMP = 2'd1,
        LD_BOTH = 2'd2
    } load_t;

    // Map a control byte to the load destination.
    function automatic load_t decode_load(input logic [CTRL_W-1:0] ctrl);
        load_t sel;
        if (ctrl[CTRL_BLK_HI] || ctrl[CTRL_BLK_LO]) begin
            sel = LD_NONE;
        end else begin
            case (ctrl[CTRL_MOD_HI:CTRL_MOD_LO])
                2'b00:   sel = LD_TEMP;
                2'b01:   sel = LD_BOTH;
                default: sel = LD_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/conv_seq_fsm.sv
// Module: conv_seq_fsm
// Tracks where the byte stream stands within a write transaction. It
// captures the control byte and the two halves of each word, and it raises
// commit_req when the acknowledge edge after a low byte arrives.
// Assumes: the receiver passes on only the bytes that follow a matched write
// address; the strobes last one cycle each; txn_start and txn_stop take
// priority over byte and acknowledge strobes in the same cycle.
module conv_seq_fsm
    import conv_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                rx_valid,
    input  logic                ack_fall,
    input  logic                txn_start,
    input  logic                txn_stop,
    output logic                commit_req,
    output logic [2*BYTE_W-1:0] word,
    output logic [CTRL_W-1:0]   ctrl
);

    localparam int WORD_W = 2 * BYTE_W;

    phase_t              phase_q, phase_d;
    logic [BYTE_W-1:0]   hi_q, lo_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic                take_ctrl, take_hi, take_lo, ack_hit;

    // Decode which capture happens this cycle
    always_comb begin
        take_ctrl = 1'b0;
        take_hi   = 1'b0;
        take_lo   = 1'b0;
        ack_hit   = 1'b0;
        if (!txn_start && !txn_stop) begin
            take_ctrl = rx_valid && (phase_q == PH_CTRL);
            take_hi   = rx_valid && (phase_q == PH_HIGH);
            take_lo   = rx_valid && (phase_q == PH_LOW);
            ack_hit   = ack_fall && (phase_q == PH_ACK);
        end
    end

    // Next phase of the transaction
    always_comb begin
        phase_d = phase_q;
        if (txn_start) begin
            phase_d = PH_CTRL;
        end else if (txn_stop) begin
            phase_d = PH_IDLE;
        end else begin
            case (phase_q)
                PH_CTRL: if (take_ctrl) phase_d = PH_HIGH;
                PH_HIGH: if (take_hi)   phase_d = PH_LOW;
                PH_LOW:  if (take_lo)   phase_d = PH_ACK;
                PH_ACK:  if (ack_hit)   phase_d = PH_HIGH;
                PH_IDLE: phase_d = PH_IDLE;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Control byte register; it holds its value until a new control byte arrives
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (take_ctrl) ctrl_q <= rx_byte;
    end

    // High and low halves of the word being assembled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (take_hi) hi_q <= rx_byte;
            if (take_lo) lo_q <= rx_byte;
        end
    end

    assign commit_req = ack_hit;
    assign word       = {hi_q, lo_q};
    assign ctrl       = ctrl_q;

    // The wait-for-acknowledge phase is reached only through the low-byte phase
    AST_ACK_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACK) |-> $past(phase_q == PH_LOW || phase_q == PH_ACK)) // R3
        else $error("AST_ACK_AFTER_LOW");

    // The phase register never holds an undefined code
    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q inside {PH_IDLE, PH_CTRL, PH_HIGH, PH_LOW, PH_ACK}) // R2
        else $error("AST_PHASE_LEGAL");

    // After stop, nothing is pending
    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_stop && !txn_start) |=> (phase_q == PH_IDLE)) // R9
        else $error("AST_STOP_CLEARS");

    logic unused_w;
    assign unused_w = ^WORD_W;

endmodule

// File: rtl/conv_word_commit.sv
// Module: conv_word_commit
// Holds the holding register and the output register. On a commit request
// it loads the assembled word into the destination chosen by the control
// byte, and it flags each output-register load with a one-cycle pulse.
// Assumes: commit_req lasts one cycle, and word and ctrl are stable in that cycle.
module conv_word_commit
    import conv_seq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_req,
    input  logic [WORD_W-1:0] word,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [WORD_W-1:0] tmp_word,
    output logic [WORD_W-1:0] out_word,
    output logic              upd_pulse
);

    load_t             sel;
    logic              ld_tmp, ld_out;
    logic [WORD_W-1:0] tmp_q, out_q;
    logic              pulse_q;

    // Choose the destination for this commit
    always_comb begin
        sel    = decode_load(ctrl);
        ld_tmp = commit_req && (sel == LD_TEMP || sel == LD_BOTH);
        ld_out = commit_req && (sel == LD_BOTH);
    end

    // Holding register
    always_ff @(posedge clk) begin
        if (!rst_n)      tmp_q <= '0;
        else if (ld_tmp) tmp_q <= word;
    end

    // Output register and its load pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= ld_out;
            if (ld_out) out_q <= word;
        end
    end

    assign tmp_word  = tmp_q;
    assign out_word  = out_q;
    assign upd_pulse = pulse_q;

    // The output register moves only in a pulse cycle
    AST_OUT_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse_q |-> $stable(out_q)) // R11
        else $error("AST_OUT_NEEDS_PULSE");

    // A load of both registers leaves them equal
    AST_BOTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (out_q == tmp_q)) // R5
        else $error("AST_BOTH_MATCH");

    // The pulse lasts one cycle (a new word needs at least three strobes)
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q) // R5
        else $error("AST_PULSE_SINGLE");

    // Without a commit request the holding register keeps its value
    AST_TMP_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_req |=> $stable(tmp_q)) // R3
        else $error("AST_TMP_ON_COMMIT");

endmodule

// File: rtl/conv_update_seq.sv
// Module: conv_update_seq (top)
// Converter register update sequencer. It joins the transaction tracker
// and the commit stage.
// Assumes: the byte receiver handles addressing and acknowledge generation.
module conv_update_seq
    import conv_seq_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  logic                rx_valid,
    input  logic                ack_fall,
    input  logic                txn_start,
    input  logic                txn_stop,
    output logic [2*BYTE_W-1:0] tmp_word,
    output logic [2*BYTE_W-1:0] out_word,
    output logic                upd_pulse
);

    localparam int WORD_W = 2 * BYTE_W;

    logic              commit_req;
    logic [WORD_W-1:0] word;
    logic [CTRL_W-1:0] ctrl;

    conv_seq_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .ack_fall   (ack_fall),
        .txn_start  (txn_start),
        .txn_stop   (txn_stop),
        .commit_req (commit_req),
        .word       (word),
        .ctrl       (ctrl)
    );

    conv_word_commit #(.WORD_W(WORD_W)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .word       (word),
        .ctrl       (ctrl),
        .tmp_word   (tmp_word),
        .out_word   (out_word),
        .upd_pulse  (upd_pulse)
    );

    // The holding register changes only in the cycle after an acknowledge edge
    AST_TMP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ack_fall) |-> $stable(tmp_word)) // R3
        else $error("AST_TMP_AFTER_ACK");

endmodule

// File: tb/conv_update_seq_bench.sv
module conv_update_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        ack_fall = 1'b0;
    logic        txn_start = 1'b0;
    logic        txn_stop = 1'b0;
    logic [15:0] tmp_word, out_word;
    logic        upd_pulse;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    done    = 1'b0;

    // Reference model state
    int       m_phase = 0;   // 0 closed, 1 want control, 2 want high, 3 want low, 4 want ack
    int       m_ctrl  = 0;
    int       m_hi    = 0;
    int       m_lo    = 0;
    int       m_tmp   = 0;
    int       m_out   = 0;
    bit       m_pulse = 0;
    bit       last_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_update_seq u_conv_update_seq (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .ack_fall(ack_fall), .txn_start(txn_start), .txn_stop(txn_stop),
        .tmp_word(tmp_word), .out_word(out_word), .upd_pulse(upd_pulse)
    );

    // Behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        m_pulse = 0;
        if (!rst_n) begin
            m_phase = 0; m_ctrl = 0; m_hi = 0; m_lo = 0; m_tmp = 0; m_out = 0;
        end else if (txn_start) begin
            m_phase = 1;
        end else if (txn_stop) begin
            m_phase = 0;
        end else if (rx_valid && m_phase >= 1 && m_phase <= 3) begin
            if (m_phase == 1)      begin m_ctrl = rx_byte; m_phase = 2; end
            else if (m_phase == 2) begin m_hi = rx_byte;   m_phase = 3; end
            else                   begin m_lo = rx_byte;   m_phase = 4; end
        end else if (ack_fall && m_phase == 4) begin
            m_phase = 2;
            if ((m_ctrl / 64) == 0) begin
                if (((m_ctrl / 16) % 4) == 0) m_tmp = m_hi * 256 + m_lo;
                if (((m_ctrl / 16) % 4) == 1) begin
                    m_tmp = m_hi * 256 + m_lo;
                    m_out = m_tmp;
                    m_pulse = 1;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Compare the design against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_req, " tmp"},   int'(tmp_word),  m_tmp);
            check({cur_req, " out"},   int'(out_word),  m_out);
            check({cur_req, " pulse"}, int'(upd_pulse), int'(m_pulse));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        idle(1);
    endtask

    task automatic ack();
        ack_fall = 1'b1;
        @(negedge clk);
        ack_fall = 1'b0;
        last_pulse = upd_pulse;
        idle(1);
    endtask

    task automatic start();
        txn_start = 1'b1; @(negedge clk); txn_start = 1'b0; idle(1);
    endtask

    task automatic stop();
        txn_stop = 1'b1; @(negedge clk); txn_stop = 1'b0; idle(1);
    endtask

    task automatic pair(input logic [7:0] h, input logic [7:0] l);
        send(h); send(l); ack();
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: reset state
        check("R1 tmp", int'(tmp_word), 0);
        check("R1 out", int'(out_word), 0);
        check("R1 pulse", int'(upd_pulse), 0);
        rst_n = 1'b1;
        idle(2);

        // R2, R3, R5: update both registers; nothing before the acknowledge
        cur_req = "R5";
        start(); send(8'h10); send(8'h12); send(8'h34);
        check("R3 no load before ack", int'(out_word), 0);
        ack();
        check("R5 pulse on load", int'(last_pulse), 1);
        check("R2 word order", int'(out_word), 16'h1234);
        idle(1);
        check("R11 pulse one cycle", int'(upd_pulse), 0);

        // R8: further pair under the same control byte
        cur_req = "R8";
        pair(8'hAB, 8'hCD);
        check("R8 second pair", int'(out_word), 16'hABCD);
        // R3: stray acknowledge after a lone high byte
        cur_req = "R3";
        send(8'h77); ack();
        check("R3 stray ack", int'(tmp_word), 16'hABCD);
        stop();

        // R4: holding register only
        cur_req = "R4";
        start(); send(8'h00); pair(8'h55, 8'hAA);
        check("R4 tmp", int'(tmp_word), 16'h55AA);
        check("R4 out kept", int'(out_word), 16'hABCD);
        check("R11 no pulse", int'(last_pulse), 0);
        stop();

        // R6: top bits set block loads
        cur_req = "R6";
        start(); send(8'hC1); pair(8'h11, 8'h22); pair(8'h33, 8'h44);
        check("R6 tmp", int'(tmp_word), 16'h55AA);
        check("R6 out", int'(out_word), 16'hABCD);
        stop();
        start(); send(8'h50); pair(8'h11, 8'h22);
        check("R6 bit6", int'(tmp_word), 16'h55AA);
        stop();

        // R7: unused mode codes
        cur_req = "R7";
        start(); send(8'h20); pair(8'h66, 8'h77);
        check("R7 mode 10", int'(tmp_word), 16'h55AA);
        stop();
        start(); send(8'h30); pair(8'h66, 8'h77);
        check("R7 mode 11", int'(out_word), 16'hABCD);
        stop();

        // R9: pairs cut short
        cur_req = "R9";
        start(); send(8'h10); send(8'h99); stop();
        start(); send(8'h10); send(8'h98); send(8'h76); stop(); ack();
        check("R9 stop before ack", int'(out_word), 16'hABCD);
        start(); send(8'h10); send(8'h98); send(8'h76);
        start(); ack(); send(8'h00); send(8'h01); send(8'h02); ack();
        check("R9 restart drops pending", int'(tmp_word), 16'h0102);
        check("R9 restart out kept", int'(out_word), 16'hABCD);
        stop();

        // R10: first byte of a new transaction is control
        cur_req = "R10";
        start(); send(8'h10); pair(8'h77, 8'h88);
        check("R10 control first", int'(out_word), 16'h7788);
        check("R10 tmp", int'(tmp_word), 16'h7788);
        stop();
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule